// File: doc/BRIEF.md
# Previous-Index Hit-Bit Trace Compressor

This block is a second compression stage for a trace of stream-cache indices. Every index that arrives is guessed from the index that came before it. A direct-mapped guess table supplies the guess, and it is addressed by a hash of a short history of accepted indices. With the default history depth of one, that hash is simply the previous index. A correct guess costs one bit in the output. A wrong guess costs one bit plus the full index, which goes out on a separate miss trace. On a wrong guess the table entry is also overwritten with the index that actually arrived.

The result bits are packed into bytes, oldest bit first, and one byte is sent for every eight indices. A flush request sends the bits still pending as a final short byte. That byte is zero-padded and tagged with its bit count, so a decoder can rebuild the index stream exactly.

The input and both output traces use valid/ready handshakes. When downstream is not stalling, the block takes one index per clock cycle.

Top module: `idx_pred_compressor`

## Requirements
- R1: After reset, pk_valid and ms_valid are 0, in_ready is 1, the history holds 0 and every table entry holds 0. An index of 0 as the very first input therefore yields a hit bit of 1.
- R2: With the default history depth of one, the guess for an index is the table entry addressed by the index accepted just before it. Before any index has been accepted, that address is 0.
- R3: When the guessed entry equals the incoming index, the result bit is 1 and no miss-trace word is produced.
- R4: When the guessed entry differs, the result bit is 0. The incoming index appears on ms_index with ms_valid set in the cycle after acceptance. The entry is rewritten, so the same predecessor followed by the same index hits next time.
- R5: Result bits are packed least significant bit first: the k-th accepted index since the last emitted byte occupies pk_data bit k. After eight results a byte is presented with pk_nbits = 8.
- R6: When flush is 1 in a cycle where in_ready is 1, the pending bits are presented as a byte. This includes the bit of an index accepted in that same cycle. Unused upper bits of that byte are 0 and pk_nbits gives the count of bits (1 to 7). A flush with nothing pending, or a flush while in_ready is 0, produces no byte.
- R7: in_ready is 1 whenever each output either holds no word or is being accepted in that cycle. Back-to-back indices are then accepted every cycle, with no bubble.
- R8: While a valid output is stalled by its ready input, its data and bit count hold steady. No byte and no miss word is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Index offered |
| in_ready | output | 1 | Index accepted when valid and ready |
| in_index | input | IDX_W | Incoming stream-cache index |
| flush | input | 1 | Emit pending partial byte (acts only while in_ready) |
| pk_valid | output | 1 | Packed hit-bit byte available |
| pk_ready | input | 1 | Packed byte consumer ready |
| pk_data | output | PACK_W | Packed result bits, LSB is oldest |
| pk_nbits | output | CNT_W | Number of meaningful bits in pk_data |
| ms_valid | output | 1 | Miss-trace index available |
| ms_ready | input | 1 | Miss-trace consumer ready |
| ms_index | output | IDX_W | Index that was mispredicted |

## Verification
The bench first targets the very first index after reset. If the table or history did not start at zero, a leading 0 would come out as a miss instead of a hit. It then targets a predecessor/successor pair repeated after a miss. A design that skipped the table update, or addressed the table with the current index instead of the previous one, would keep emitting miss words there. Flushes are issued with no bits pending, in the same cycle as an index, and while in_ready is low. A design that got any of these wrong would emit an empty byte, drop the last bit, or emit a byte it should not have. Random stalls on both outputs expose a design that changes or loses a held word.

// File: rtl/idx_pred_pkg.sv
package idx_pred_pkg;

   localparam int unsigned IDXP_MAX_HIST = 8;

   function automatic int unsigned idxp_cnt_width(input int unsigned n);
      return $clog2(n + 1);
   endfunction

endpackage

// File: rtl/idx_pred_hist.sv
module idx_pred_hist #(
   parameter int unsigned IDX_W    = 8,
   parameter int unsigned PRED_AW  = 8,
   parameter int unsigned HIST_LEN = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push,
   input  logic [IDX_W-1:0]   push_idx,
   output logic [PRED_AW-1:0] pred_addr
);

   logic [IDX_W-1:0] hist_q [HIST_LEN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q[0] <= '0;
      end else if (push) begin
         hist_q[0] <= push_idx;
      end
   end

   for (genvar k = 1; k < HIST_LEN; k++) begin : g_shift
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hist_q[k] <= '0;
         end else if (push) begin
            hist_q[k] <= hist_q[k-1];
         end
      end
   end

   if (HIST_LEN == 1) begin : g_direct
      assign pred_addr = hist_q[0][PRED_AW-1:0];
   end else begin : g_fold
      always_comb begin
         pred_addr = '0;
         for (int k = 0; k < HIST_LEN; k++) begin
            pred_addr = pred_addr ^ hist_q[k][PRED_AW-1:0];
         end
      end
   end

   // R2: the address after a push reflects the pushed index (single-entry history)
   if (HIST_LEN == 1) begin : g_chk
      a_r2_hist_follows: assert property (@(posedge clk) disable iff (!rst_n)
         push |=> pred_addr == $past(push_idx[PRED_AW-1:0]));
   end

endmodule

// File: rtl/idx_pred_table.sv
module idx_pred_table #(
   parameter int unsigned IDX_W   = 8,
   parameter int unsigned PRED_AW = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PRED_AW-1:0] rd_addr,
   output logic [IDX_W-1:0]   rd_data,
   input  logic               wr_en,
   input  logic [PRED_AW-1:0] wr_addr,
   input  logic [IDX_W-1:0]   wr_data
);

   localparam int unsigned DEPTH = 1 << PRED_AW;

   logic [IDX_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem_q[i] <= '0;
         end
      end else if (wr_en) begin
         mem_q[wr_addr] <= wr_data;
      end
   end

   assign rd_data = mem_q[rd_addr];

   // R4: a written entry reads back when the same address is looked up next
   a_r4_table_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_addr == wr_addr) |=> (rd_addr != $past(wr_addr)) || (rd_data == $past(wr_data)));

endmodule

// File: rtl/idx_pred_packer.sv
module idx_pred_packer #(
   parameter int unsigned PACK_W = 8,
   parameter int unsigned CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              bit_val,
   input  logic              flush_en,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [PACK_W-1:0] out_data,
   output logic [CNT_W-1:0]  out_nbits
);

   logic [PACK_W-1:0] acc_q, acc_nx;
   logic [CNT_W-1:0]  cnt_q, cnt_nx;
   logic              emit;

   always_comb begin
      acc_nx = acc_q;
      if (bit_en) begin
         acc_nx = acc_q | (PACK_W'(bit_val) << cnt_q);
      end
      cnt_nx = cnt_q + CNT_W'(bit_en);
      emit   = (cnt_nx == CNT_W'(PACK_W)) || (flush_en && cnt_nx != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q     <= '0;
         cnt_q     <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_nbits <= '0;
      end else begin
         if (emit) begin
            acc_q     <= '0;
            cnt_q     <= '0;
            out_valid <= 1'b1;
            out_data  <= acc_nx;
            out_nbits <= cnt_nx;
         end else begin
            acc_q <= acc_nx;
            cnt_q <= cnt_nx;
            if (out_ready) begin
               out_valid <= 1'b0;
            end
         end
      end
   end

   // R6: a presented byte carries 1..PACK_W bits and zero padding above them
   a_r6_nbits_range: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_nbits != '0) && (out_nbits <= CNT_W'(PACK_W)));
   a_r6_zero_pad: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_data >> out_nbits) == '0));
   // R8: a stalled byte stays put
   a_r8_pk_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_nbits));
   // R5: pending bit count never reaches a full byte between cycles
   a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CNT_W'(PACK_W));

endmodule

// File: rtl/idx_pred_compressor.sv
module idx_pred_compressor #(
   parameter int unsigned IDX_W    = 8,
   parameter int unsigned PRED_AW  = 8,
   parameter int unsigned HIST_LEN = 1,
   parameter int unsigned PACK_W   = 8,
   parameter int unsigned CNT_W    = idx_pred_pkg::idxp_cnt_width(PACK_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [IDX_W-1:0]  in_index,
   input  logic              flush,
   output logic              pk_valid,
   input  logic              pk_ready,
   output logic [PACK_W-1:0] pk_data,
   output logic [CNT_W-1:0]  pk_nbits,
   output logic              ms_valid,
   input  logic              ms_ready,
   output logic [IDX_W-1:0]  ms_index
);

   if (PRED_AW > IDX_W) begin : g_bad_aw
      $error("PRED_AW must not exceed IDX_W");
   end
   if (HIST_LEN < 1 || HIST_LEN > idx_pred_pkg::IDXP_MAX_HIST) begin : g_bad_hist
      $error("HIST_LEN out of range");
   end
   if (CNT_W < idx_pred_pkg::idxp_cnt_width(PACK_W)) begin : g_bad_cnt
      $error("CNT_W too narrow for PACK_W");
   end

   logic               acc_go, flush_go, hit;
   logic [PRED_AW-1:0] pred_addr;
   logic [IDX_W-1:0]   pred_idx;

   assign in_ready = (!pk_valid || pk_ready) && (!ms_valid || ms_ready);
   assign acc_go   = in_valid && in_ready;
   assign flush_go = flush && in_ready;
   assign hit      = (pred_idx == in_index);

   idx_pred_hist #(
      .IDX_W(IDX_W), .PRED_AW(PRED_AW), .HIST_LEN(HIST_LEN)
   ) u_hist (
      .clk(clk), .rst_n(rst_n), .push(acc_go), .push_idx(in_index),
      .pred_addr(pred_addr)
   );

   idx_pred_table #(
      .IDX_W(IDX_W), .PRED_AW(PRED_AW)
   ) u_table (
      .clk(clk), .rst_n(rst_n), .rd_addr(pred_addr), .rd_data(pred_idx),
      .wr_en(acc_go && !hit), .wr_addr(pred_addr), .wr_data(in_index)
   );

   idx_pred_packer #(
      .PACK_W(PACK_W), .CNT_W(CNT_W)
   ) u_pack (
      .clk(clk), .rst_n(rst_n), .bit_en(acc_go), .bit_val(hit),
      .flush_en(flush_go), .out_valid(pk_valid), .out_ready(pk_ready),
      .out_data(pk_data), .out_nbits(pk_nbits)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ms_valid <= 1'b0;
         ms_index <= '0;
      end else if (acc_go && !hit) begin
         ms_valid <= 1'b1;
         ms_index <= in_index;
      end else if (ms_ready) begin
         ms_valid <= 1'b0;
      end
   end

   // R3: a correct guess leaves the miss trace empty
   a_r3_hit_no_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_go && hit) |=> !ms_valid);
   // R4: a wrong guess shows up on the miss trace next cycle
   a_r4_miss_out: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_go && !hit) |=> ms_valid && (ms_index == $past(in_index)));
   // R7: idle outputs never block the input
   a_r7_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!pk_valid && !ms_valid) |-> in_ready);
   // R8: a stalled miss word stays put
   a_r8_ms_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ms_valid && !ms_ready) |=> ms_valid && $stable(ms_index));

endmodule

// File: tb/tb_idx_pred_compressor.sv
module tb_idx_pred_compressor;

   localparam int CLK_PERIOD = 10;
   localparam int IW = 8;
   localparam int PW = 8;
   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0, flush = 1'b0, pk_ready = 1'b1, ms_ready = 1'b1;
   logic [IW-1:0] in_index = '0;
   logic          in_ready, pk_valid, ms_valid;
   logic [PW-1:0] pk_data;
   logic [CW-1:0] pk_nbits;
   logic [IW-1:0] ms_index;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   logic [IW-1:0] m_tbl [256];
   logic [IW-1:0] m_prev;
   logic [PW-1:0] m_acc;
   int            m_cnt;
   logic [PW+CW-1:0] q_pk [$];
   string            q_tag [$];
   logic [IW-1:0]    q_ms [$];
   int               stall_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   idx_pred_compressor dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_index(in_index), .flush(flush), .pk_valid(pk_valid), .pk_ready(pk_ready),
      .pk_data(pk_data), .pk_nbits(pk_nbits), .ms_valid(ms_valid),
      .ms_ready(ms_ready), .ms_index(ms_index)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 256; i++) m_tbl[i] = '0;
      m_prev = '0; m_acc = '0; m_cnt = 0;
   endtask

   task automatic model_emit(input string tag);
      q_pk.push_back({CW'(m_cnt), m_acc});
      q_tag.push_back(tag);
      m_acc = '0; m_cnt = 0;
   endtask

   task automatic model_step(input logic [IW-1:0] idx);
      logic h;
      h = (m_tbl[m_prev] == idx);
      if (!h) begin
         q_ms.push_back(idx);
         m_tbl[m_prev] = idx;
      end
      m_prev = idx;
      m_acc[m_cnt] = h;
      m_cnt++;
      if (m_cnt == PW) model_emit("R2 R3 R5 byte");
   endtask

   // drive one cycle at the falling edge, observe transfers, advance
   task automatic cyc(input logic v, input logic [IW-1:0] idx, input logic fl,
                      input logic pr, input logic mr);
      in_valid = v; in_index = idx; flush = fl; pk_ready = pr; ms_ready = mr;
      #1;
      if (pk_valid && pk_ready) begin
         if (q_pk.size() == 0) check("R6 unexpected byte", {pk_nbits, pk_data}, 32'hFFFF);
         else begin
            check({q_tag[0], " data/nbits"}, {pk_nbits, pk_data}, q_pk[0]);
            void'(q_pk.pop_front()); void'(q_tag.pop_front());
         end
      end
      if (ms_valid && ms_ready) begin
         if (q_ms.size() == 0) check("R3 unexpected miss word", ms_index, 32'hFFFF);
         else begin
            check("R4 miss index", ms_index, q_ms[0]);
            void'(q_ms.pop_front());
         end
      end
      if (v && !in_ready && pr && mr && !pk_valid && !ms_valid) stall_cnt++;
      if (v && in_ready) model_step(idx);
      if (fl && in_ready && m_cnt != 0) model_emit("R6 flush");
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [IW-1:0] r;
      void'($urandom(32'd4242));
      model_reset();
      repeat (3) @(negedge clk);
      // R1: reset state at the ports
      check("R1 pk_valid", pk_valid, 0);
      check("R1 ms_valid", ms_valid, 0);
      check("R1 in_ready", in_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: first index 0 hits on cleared table, flushed alone -> 0x01, 1 bit
      cyc(1, 8'h00, 1, 1, 1);
      cyc(0, 0, 0, 1, 1);
      check("R1 first-zero byte seen", q_pk.size(), 0);
      // R6: flush with nothing pending gives no byte
      cyc(0, 0, 1, 1, 1);
      cyc(0, 0, 0, 1, 1);
      check("R6 empty flush silent", pk_valid, 0);
      // R2 R4: alternating pair learns after one miss each
      for (int i = 0; i < 8; i++) cyc(1, (i % 2) ? 8'h07 : 8'h05, 0, 1, 1);
      cyc(0, 0, 0, 1, 1);
      // R6: partial byte of 3 with the last bit accepted with the flush
      cyc(1, 8'h05, 0, 1, 1);
      cyc(1, 8'h07, 0, 1, 1);
      cyc(1, 8'h09, 1, 1, 1);
      cyc(0, 0, 0, 1, 1);
      // R6 R8: flush while in_ready is low is ignored
      for (int i = 0; i < 8; i++) cyc(1, 8'(i), 0, 1, 1);
      cyc(1, 8'h33, 0, 0, 1);
      cyc(0, 0, 1, 0, 1);
      check("R8 stalled byte held", pk_valid, 1);
      cyc(0, 0, 0, 1, 1);
      cyc(0, 0, 0, 1, 1);
      check("R6 ignored flush left no byte", pk_valid, 0);
      // R7: full-rate random stream, outputs always ready
      for (int i = 0; i < 2000; i++) begin
         r = ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'($urandom_range(0, 5));
         cyc(1, r, ($urandom_range(0, 40) == 0), 1, 1);
      end
      check("R7 no bubble at full rate", stall_cnt, 0);
      // R8: random backpressure on both outputs
      for (int i = 0; i < 4000; i++) begin
         r = ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'($urandom_range(0, 5));
         cyc($urandom_range(0, 3) != 0, r, ($urandom_range(0, 30) == 0),
             $urandom_range(0, 2) != 0, $urandom_range(0, 2) != 0);
      end
      cyc(0, 0, 1, 1, 1);
      for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 1);
      check("R8 no byte lost", q_pk.size(), 0);
      check("R8 no miss word lost", q_ms.size(), 0);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule